// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block performs one logical block update on a five-column disk array whose parity column moves from row to row. A client presents a logical block number and a new data word. The engine turns the number into a row and two physical columns: the column that holds the data block and the column that holds that row's parity. It then runs the read-modify-write sequence on a per-disk command port. It fetches the old data and the old parity, writes the new data, and writes the parity recomputed as the XOR of old data, new data and old parity.

The disk port carries a column select, a row index, one-cycle read and write strobes, write data, read data and an acknowledge. Each operation waits for its acknowledge before the next one is issued, so any disk latency of at least one cycle is tolerated. The engine takes a new request only when idle. It stays busy until the last write is acknowledged and then raises a one-cycle completion pulse.

Top module: `stripe_rmw_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `done`, `dsk_rd` and `dsk_wr` are all 0.
- R2: For row r the parity column is 4 - (r mod 5). Row 0 uses column 4, row 4 uses column 0, and row 5 uses column 4 again.
- R3: Logical block n maps to row n/4 and slot s = n mod 4. The data column is s when s is below the parity column of that row, and s+1 otherwise. The data column never equals the parity column.
- R4: One accepted request issues exactly four operations in this order: a read of the data column, a read of the parity column, a write of the data column and a write of the parity column. All four use the same row. The first read strobe appears in the cycle after acceptance.
- R5: The data write carries the request data. The parity write carries old data XOR new data XOR old parity, where the old values are the words returned by the two reads. After every update, each row's parity block equals the XOR of its four data blocks.
- R6: No operation is issued before the previous one is acknowledged, so both reads complete before either write is issued.
- R7: `busy` is 1 from the cycle after acceptance until the acknowledge of the parity write. `done` is 1 for exactly one cycle, the cycle after that acknowledge, and `busy` is 0 in that cycle.
- R8: A request presented while `busy` or `done` is 1 is ignored. It causes no operation and changes no disk content.
- R9: Each strobe lasts one cycle, and a read strobe and a write strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when the engine is idle |
| req_lbn | input | 18 | Logical block number |
| req_data | input | 32 | New block data |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| dsk_sel | output | 3 | Disk column of the current operation |
| dsk_row | output | 16 | Row of the current operation |
| dsk_rd | output | 1 | Read strobe, one cycle |
| dsk_wr | output | 1 | Write strobe, one cycle |
| dsk_wdata | output | 32 | Write data |
| dsk_rdata | input | 32 | Read data, valid with the acknowledge |
| dsk_ack | input | 1 | Operation complete |

## Verification
Block numbers 0 to 59 are swept in order. This crosses the whole rotation three times, so every slot lands before, on and after the parity column. A wrong column shift or a wrong rotation direction therefore appears in the logged operation list. A second pass rewrites the first twenty blocks. The old data and old parity the engine reads are then earlier results of its own work rather than seeded values, which catches a wrong XOR operand. Disk latency cycles through 1 to 3 cycles to expose any strobe issued ahead of an acknowledge. Every seventh write holds a stray request through the busy and done cycles, which shows whether requests are taken early.

// File: rtl/srmw_pkg.sv
package srmw_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RD_OLD = 3'd1,
        PH_RD_PAR = 3'd2,
        PH_WR_NEW = 3'd3,
        PH_WR_PAR = 3'd4,
        PH_FIN    = 3'd5
    } phase_e;
endpackage

// File: rtl/stripe_map.sv
module stripe_map #(
    parameter int NCOL  = 5,
    parameter int ROW_W = 16,
    parameter int COL_W = 3,
    parameter int LBN_W = 18
) (
    input  logic [LBN_W-1:0] lbn,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] dcol,
    output logic [COL_W-1:0] pcol
);
    localparam int NDATA = NCOL - 1;

    logic [LBN_W-1:0] quo, rem;
    logic [ROW_W-1:0] rmod;
    logic [COL_W-1:0] slot;

    always_comb begin
        quo  = lbn / LBN_W'(NDATA);
        rem  = lbn % LBN_W'(NDATA);
        row  = quo[ROW_W-1:0];
        rmod = row % ROW_W'(NCOL);
        pcol = COL_W'(NCOL - 1) - rmod[COL_W-1:0];
        slot = rem[COL_W-1:0];
        dcol = (slot >= pcol) ? slot + COL_W'(1) : slot;
    end

    logic unused_hi;
    assign unused_hi = ^{quo[LBN_W-1:ROW_W], rem[LBN_W-1:COL_W], rmod[ROW_W-1:COL_W]};
endmodule

// File: rtl/parity_merge.sv
module parity_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] old_d,
    input  logic [DW-1:0] new_d,
    input  logic [DW-1:0] old_p,
    output logic [DW-1:0] new_p
);
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign new_p[b] = old_d[b] ^ new_d[b] ^ old_p[b];
    end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import srmw_pkg::*;
#(
    parameter int DW    = 32,
    parameter int ROW_W = 16,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DW-1:0]    req_data,
    input  logic [ROW_W-1:0] map_row,
    input  logic [COL_W-1:0] map_dcol,
    input  logic [COL_W-1:0] map_pcol,
    input  logic [DW-1:0]    par_in,
    input  logic             dsk_ack,
    input  logic [DW-1:0]    dsk_rdata,
    output logic [DW-1:0]    old_data,
    output logic [DW-1:0]    new_data,
    output logic             busy,
    output logic             done,
    output logic [COL_W-1:0] dsk_sel,
    output logic [ROW_W-1:0] dsk_row,
    output logic             dsk_rd,
    output logic             dsk_wr,
    output logic [DW-1:0]    dsk_wdata
);
    typedef struct packed {
        phase_e           ph;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] dcol;
        logic [COL_W-1:0] pcol;
        logic [DW-1:0]    newd;
        logic [DW-1:0]    oldd;
        logic [DW-1:0]    par;
        logic [COL_W-1:0] sel;
        logic             rd;
        logic             wr;
        logic [DW-1:0]    wdata;
        logic             done;
    } ctl_s;

    ctl_s st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.rd   = 1'b0;
        st_d.wr   = 1'b0;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: if (req_valid) begin
                st_d.ph   = PH_RD_OLD;
                st_d.row  = map_row;
                st_d.dcol = map_dcol;
                st_d.pcol = map_pcol;
                st_d.newd = req_data;
                st_d.sel  = map_dcol;
                st_d.rd   = 1'b1;
            end
            PH_RD_OLD: if (dsk_ack) begin
                st_d.oldd = dsk_rdata;
                st_d.sel  = st_q.pcol;
                st_d.rd   = 1'b1;
                st_d.ph   = PH_RD_PAR;
            end
            PH_RD_PAR: if (dsk_ack) begin
                st_d.par   = par_in;
                st_d.sel   = st_q.dcol;
                st_d.wr    = 1'b1;
                st_d.wdata = st_q.newd;
                st_d.ph    = PH_WR_NEW;
            end
            PH_WR_NEW: if (dsk_ack) begin
                st_d.sel   = st_q.pcol;
                st_d.wr    = 1'b1;
                st_d.wdata = st_q.par;
                st_d.ph    = PH_WR_PAR;
            end
            PH_WR_PAR: if (dsk_ack) begin
                st_d.ph   = PH_FIN;
                st_d.done = 1'b1;
            end
            PH_FIN:  st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign old_data  = st_q.oldd;
    assign new_data  = st_q.newd;
    assign busy      = (st_q.ph != PH_IDLE) && (st_q.ph != PH_FIN);
    assign done      = st_q.done;
    assign dsk_sel   = st_q.sel;
    assign dsk_row   = st_q.row;
    assign dsk_rd    = st_q.rd;
    assign dsk_wr    = st_q.wr;
    assign dsk_wdata = st_q.wdata;

    assert_accept_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && req_valid) |=> (dsk_rd && busy));
    assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsk_rd && dsk_wr));
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_rd || dsk_wr) |=> !(dsk_rd || dsk_wr));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_data_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RD_PAR && dsk_ack) |=> (dsk_wr && dsk_wdata == new_data));
    assert_cols_differ_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.dcol != st_q.pcol));
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(new_data));
endmodule

// File: rtl/stripe_rmw_engine.sv
module stripe_rmw_engine #(
    parameter  int DATA_W = 32,
    parameter  int ROW_W  = 16,
    parameter  int NCOL   = 5,
    localparam int COL_W  = $clog2(NCOL),
    localparam int LBN_W  = ROW_W + $clog2(NCOL - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LBN_W-1:0]  req_lbn,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [COL_W-1:0]  dsk_sel,
    output logic [ROW_W-1:0]  dsk_row,
    output logic              dsk_rd,
    output logic              dsk_wr,
    output logic [DATA_W-1:0] dsk_wdata,
    input  logic [DATA_W-1:0] dsk_rdata,
    input  logic              dsk_ack
);
    logic [ROW_W-1:0]  m_row;
    logic [COL_W-1:0]  m_dcol, m_pcol;
    logic [DATA_W-1:0] par_w, oldd_w, newd_w;

    stripe_map #(.NCOL(NCOL), .ROW_W(ROW_W), .COL_W(COL_W), .LBN_W(LBN_W)) u_map (
        .lbn(req_lbn), .row(m_row), .dcol(m_dcol), .pcol(m_pcol)
    );

    parity_merge #(.DW(DATA_W)) u_par (
        .old_d(oldd_w), .new_d(newd_w), .old_p(dsk_rdata), .new_p(par_w)
    );

    rmw_ctrl #(.DW(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .map_row(m_row), .map_dcol(m_dcol), .map_pcol(m_pcol), .par_in(par_w),
        .dsk_ack(dsk_ack), .dsk_rdata(dsk_rdata), .old_data(oldd_w), .new_data(newd_w),
        .busy(busy), .done(done), .dsk_sel(dsk_sel), .dsk_row(dsk_row),
        .dsk_rd(dsk_rd), .dsk_wr(dsk_wr), .dsk_wdata(dsk_wdata)
    );
endmodule

// File: tb/tb_stripe_rmw_engine.sv
`timescale 1ns/1ps
module tb_stripe_rmw_engine;
    localparam int DW = 32, RW = 16, NC = 5, LW = 18, NR = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, req_valid = 1'b0;
    logic [LW-1:0] req_lbn = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, done, dsk_rd, dsk_wr;
    logic [2:0]    dsk_sel;
    logic [RW-1:0] dsk_row;
    logic [DW-1:0] dsk_wdata;
    logic [DW-1:0] dsk_rdata = '0;
    logic          dsk_ack = 1'b0;

    stripe_rmw_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lbn(req_lbn),
        .req_data(req_data), .busy(busy), .done(done), .dsk_sel(dsk_sel),
        .dsk_row(dsk_row), .dsk_rd(dsk_rd), .dsk_wr(dsk_wr), .dsk_wdata(dsk_wdata),
        .dsk_rdata(dsk_rdata), .dsk_ack(dsk_ack)
    );

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    // disk model and operation log
    logic [DW-1:0] mem [NC][NR];
    logic [DW-1:0] sh  [NC][NR];
    int lat = 1, cnt = 0, viol = 0, op_n = 0;
    bit pend = 0, p_wr = 0;
    int p_sel = 0, p_row = 0;
    logic [DW-1:0] p_wd = '0;
    bit op_wr [8];
    int op_sel [8];
    int op_row [8];
    logic [DW-1:0] op_wd [8];

    always @(posedge clk) begin
        bit was;
        was = pend;
        dsk_ack <= 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                dsk_ack <= 1'b1;
                if (p_wr) mem[p_sel][p_row] <= p_wd;
                else      dsk_rdata <= mem[p_sel][p_row];
                pend = 0;
            end else cnt = cnt - 1;
        end
        if (dsk_rd || dsk_wr) begin
            if (was || (dsk_rd && dsk_wr)) viol++;
            pend = 1; cnt = lat; p_wr = dsk_wr;
            p_sel = int'(dsk_sel); p_row = int'(dsk_row); p_wd = dsk_wdata;
            if (op_n < 8) begin
                op_wr[op_n] = dsk_wr; op_sel[op_n] = p_sel;
                op_row[op_n] = p_row; op_wd[op_n] = dsk_wdata;
            end
            op_n++;
        end
    end

    task automatic do_write(input int lbn, input logic [DW-1:0] d, input bit stray);
        int row, slot, pc, dc, t, tack;
        logic [DW-1:0] ep;
        row = lbn / 4; slot = lbn % 4; pc = 4 - (row % 5);
        dc = (slot >= pc) ? slot + 1 : slot;
        ep = sh[dc][row] ^ d ^ sh[pc][row];
        lat = 1 + (lbn % 3);
        @(negedge clk);
        op_n = 0; viol = 0;
        req_valid = 1'b1; req_lbn = LW'(lbn); req_data = d;
        @(negedge clk);
        req_valid = stray;
        if (stray) begin req_lbn = LW'(63); req_data = ~d; end
        chk(busy == 1'b1 && dsk_rd == 1'b1, "R7", "busy/read after accept", {busy, dsk_rd}, 2'b11);
        t = 0; tack = -10;
        while (!done && t < 200) begin
            if (dsk_ack) tack = t;
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1 && t == tack + 1, "R7", "done one cycle after last ack", t, tack + 1);
        chk(busy == 1'b0, "R7", "busy low with done", busy, 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7", "done pulse width", done, 0);
        chk(op_n == 4, "R4", "operation count", op_n, 4);
        chk(viol == 0, "R6", "issue before ack or dual strobe (R9)", viol, 0);
        chk(!op_wr[0] && op_sel[0] == dc && op_row[0] == row, "R3",
            "read old data", {op_wr[0], 8'(op_sel[0]), 16'(op_row[0])}, {1'b0, 8'(dc), 16'(row)});
        chk(!op_wr[1] && op_sel[1] == pc && op_row[1] == row, "R2",
            "read old parity", {op_wr[1], 8'(op_sel[1]), 16'(op_row[1])}, {1'b0, 8'(pc), 16'(row)});
        chk(op_wr[2] && op_sel[2] == dc && op_row[2] == row && op_wd[2] == d, "R5",
            "write new data", {op_wr[2], 8'(op_sel[2]), op_wd[2]}, {1'b1, 8'(dc), d});
        chk(op_wr[3] && op_sel[3] == pc && op_row[3] == row && op_wd[3] == ep, "R5",
            "write new parity", {op_wr[3], 8'(op_sel[3]), op_wd[3]}, {1'b1, 8'(pc), ep});
        sh[dc][row] = d; sh[pc][row] = ep;
        if (stray) begin
            repeat (4) @(negedge clk);
            chk(op_n == 4 && busy == 1'b0, "R8", "stray request ignored", op_n, 4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R7 watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC; c++) begin
                if (c != 4 - (r % 5)) mem[c][r] = DW'((r * 977 + c * 131 + 7) * 40503);
            end
            mem[4 - (r % 5)][r] = '0;
            for (int c = 0; c < NC; c++)
                if (c != 4 - (r % 5)) mem[4 - (r % 5)][r] ^= mem[c][r];
            for (int c = 0; c < NC; c++) sh[c][r] = mem[c][r];
        end
        repeat (3) @(negedge clk);
        chk({busy, done, dsk_rd, dsk_wr} == 4'b0, "R1", "outputs in reset", {busy, done, dsk_rd, dsk_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, dsk_rd, dsk_wr} == 4'b0, "R1", "outputs after reset", {busy, done, dsk_rd, dsk_wr}, 0);
        for (int n = 0; n < 60; n++)
            do_write(n, DW'(32'h9E3779B9 * (n + 1)) ^ DW'(n << 8), (n % 7) == 3);
        for (int n = 0; n < 20; n++)
            do_write(n, DW'(32'h7F4A7C15 * (n + 3)), (n % 7) == 5);
        repeat (3) @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            logic [DW-1:0] x;
            x = '0;
            for (int c = 0; c < NC; c++) x ^= mem[c][r];
            chk(x == '0, "R5", "row parity invariant", x, 0);
            for (int c = 0; c < NC; c++)
                chk(mem[c][r] == sh[c][r], "R8", "disk content", mem[c][r], sh[c][r]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule